// File: doc/BRIEF.md
# Gated Clock Fanout with Falling-Edge Enables

This block distributes one clock to a bank of outputs. A select input picks either the fast system clock or a slower scan clock. The chosen clock drives every output through its own gate. Each gate is opened or closed by an enable flip-flop, and that flip-flop is clocked on the falling edge of the chosen clock. So an output can only start or stop while the clock is low. No output ever carries a shortened high pulse.

The block has two kinds of disable. A shared disable turns off every output at once. A separate disable per output turns off one output on its own, for example to silence one card on a backplane. Both kinds of disable may change at any time relative to the clocks. The falling-edge flip-flops are the single point where they are sampled.

The select input itself is not made glitch-free. It should only change while both clocks are low.

Top module: `clkfan_gate_top`

## Requirements
- R1: With `src_sel` low, every enabled output carries the main clock `clk_main`: it is high during each high phase of that clock.
- R2: With `src_sel` high, every enabled output carries the scan clock `clk_scan` in the same way.
- R3: When `off_all` is high at a falling edge of the selected clock, every output is low from that edge until a falling edge that samples `off_all` low again.
- R4: When bit i of `off_one` is high at a falling edge of the selected clock, output i is low from that edge on. The other outputs are not affected.
- R5: Output i is enabled only when both `off_all` and `off_one[i]` are low at a falling edge. A change on either input takes effect only at the next falling edge of the selected clock. Until that edge, the output keeps its previous gating.
- R6: Every high pulse on any output lasts a full high phase of the selected clock, even while the disables toggle at arbitrary times.
- R7: While `rst_n` is low, all enable flip-flops are cleared and all outputs stay low. After `rst_n` is released, the outputs stay low until the first falling edge of the selected clock.
- R8: When an output is re-enabled, its first high pulse is the complete high phase that follows the falling edge which sampled the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | Fast system clock, chosen when `src_sel` is low |
| clk_scan | input | 1 | Slow scan or test clock, chosen when `src_sel` is high |
| rst_n | input | 1 | Active-low asynchronous reset of the enable flip-flops |
| src_sel | input | 1 | Clock source select (0 = main, 1 = scan) |
| off_all | input | 1 | Shared disable for all outputs, active high |
| off_one | input | 6 | Per-output disables, bit i disables output i, active high |
| clk_out | output | 6 | Gated clock outputs, bit i is output i |

## Verification
A disable or enable change is sampled at the first falling edge of the selected clock that follows it. It then shows on the outputs during the high phase that comes next. The bench keeps its own model of the enable state and updates it on each falling edge of its own view of the selected clock. It compares the outputs with that model 2 ns after every rising edge, which is always inside the high phase. Stimulus is applied 3 ns past a main-clock edge, so it never coincides with an edge of either clock. Each output's high pulses are timed and compared with the half period of the clock that was selected when the pulse began.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned OUT_COUNT = 6;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_SCAN = 1'b1
    } src_e;
endpackage

// File: rtl/clkfan_src_pick.sv
module clkfan_src_pick
    import clkfan_pkg::*;
(
    input  logic clk_main,
    input  logic clk_scan,
    input  logic src_sel,
    output logic clk_sel
);
    timeunit 1ns;
    timeprecision 1ps;

    src_e src;

    always_comb begin
        src = src_e'(src_sel);
        clk_sel = (src == SRC_SCAN) ? clk_scan : clk_main;
    end
endmodule

// File: rtl/clkfan_gate_ctrl.sv
module clkfan_gate_ctrl #(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic               clk_sel,
    input  logic               rst_n,
    input  logic               off_all,
    input  logic [NUM_OUT-1:0] off_one,
    output logic [NUM_OUT-1:0] gate_en
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [NUM_OUT-1:0] en;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = ~({NUM_OUT{off_all}} | off_one);
    end

    always_ff @(negedge clk_sel or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_en = st_q.en;

    always @(negedge clk_sel) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (st_q.en == '0) else $error("enables not cleared in reset"); // R7
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
        AST_OWN_OFF: assert property (@(negedge clk_sel) disable iff (!rst_n)
            off_one[i] |=> !gate_en[i]); // R4
        AST_BOTH_ON: assert property (@(negedge clk_sel) disable iff (!rst_n)
            (!off_all && !off_one[i]) |=> gate_en[i]); // R5
    end
endmodule

// File: rtl/clkfan_gate_top.sv
module clkfan_gate_top
    import clkfan_pkg::*;
#(
    parameter int unsigned NUM_OUT = OUT_COUNT
) (
    input  logic               clk_main,
    input  logic               clk_scan,
    input  logic               rst_n,
    input  logic               src_sel,
    input  logic               off_all,
    input  logic [NUM_OUT-1:0] off_one,
    output logic [NUM_OUT-1:0] clk_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic               clk_sel;
    logic [NUM_OUT-1:0] gate_en;

    clkfan_src_pick u_pick (
        .clk_main (clk_main),
        .clk_scan (clk_scan),
        .src_sel  (src_sel),
        .clk_sel  (clk_sel)
    );

    clkfan_gate_ctrl #(.NUM_OUT(NUM_OUT)) u_ctrl (
        .clk_sel (clk_sel),
        .rst_n   (rst_n),
        .off_all (off_all),
        .off_one (off_one),
        .gate_en (gate_en)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
        assign clk_out[i] = clk_sel & gate_en[i];
    end

    AST_COMMON_OFF: assert property (@(negedge clk_sel) disable iff (!rst_n)
        off_all |=> (gate_en == '0)); // R3
endmodule

// File: tb/clkfan_gate_top_test.sv
module clkfan_gate_top_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N = 6;
    localparam real MAIN_HALF = 10.0;
    localparam real SCAN_HALF = 40.0;

    logic         clk_main = 1'b1;
    logic         clk_scan = 1'b1;
    logic         rst_n = 1'b0;
    logic         src_sel = 1'b0;
    logic         off_all = 1'b0;
    logic [N-1:0] off_one = '0;
    logic [N-1:0] clk_out;
    logic [N-1:0] exp_en;
    logic         bsel;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;

    always #10 clk_main = ~clk_main;
    always #40 clk_scan = ~clk_scan;

    assign bsel = src_sel ? clk_scan : clk_main;

    clkfan_gate_top uut (
        .clk_main (clk_main),
        .clk_scan (clk_scan),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .off_all  (off_all),
        .off_one  (off_one),
        .clk_out  (clk_out)
    );

    function automatic logic [N-1:0] want_en(input logic da, input logic [N-1:0] d);
        return ~({N{da}} | d);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge bsel or negedge rst_n) begin
        if (!rst_n) exp_en <= '0;
        else        exp_en <= want_en(off_all, off_one);
    end

    always @(posedge bsel) begin
        #2;
        if (rst_n && !done)
            chk(clk_out == exp_en, src_sel ? "R2" : "R1", clk_out, exp_en);
    end

    for (genvar g = 0; g < N; g++) begin : g_mon
        realtime rise_t = 0.0;
        real     need = 0.0;
        always @(posedge clk_out[g]) begin
            rise_t = $realtime;
            need = src_sel ? SCAN_HALF : MAIN_HALF;
        end
        always @(negedge clk_out[g]) begin
            if (rst_n && !done)
                chk(($realtime - rise_t) >= need - 0.01, "R6 R8 pulse width",
                    N'(int'($realtime - rise_t)), N'(int'(need)));
        end
    end

    task automatic at_slot();
        @(posedge clk_main);
        #3;
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog act=%b exp=%b", clk_out, exp_en);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) at_slot();
        chk(clk_out == '0, "R7 in reset", clk_out, '0);
        @(posedge clk_main);
        #2;
        chk(clk_out == '0, "R7 clock high in reset", clk_out, '0);
        #1;
        rst_n = 1'b1;
        #2;
        chk(clk_out == '0, "R7 before first falling edge", clk_out, '0);
        at_slot();
        chk(clk_out == '1, "R8 first pulse after reset", clk_out, '1);

        off_all = 1'b1;
        #2;
        chk(clk_out == '1, "R5 held until falling edge", clk_out, '1);
        at_slot();
        chk(clk_out == '0, "R3 common off", clk_out, '0);

        off_all = 1'b0;
        off_one = 6'b000101;
        at_slot();
        chk(clk_out == 6'b111010, "R4 per-output off", clk_out, 6'b111010);
        chk(clk_out == 6'b111010, "R5 both must be low", clk_out, 6'b111010);

        off_one = '0;
        @(negedge clk_scan);
        #15;
        src_sel = 1'b1;
        @(posedge clk_scan);
        #2;
        chk(clk_out == '1, "R2 scan source", clk_out, '1);

        for (int k = 0; k < 600; k++) begin
            repeat ($urandom_range(0, 3)) @(posedge clk_main);
            #3;
            if ($urandom_range(0, 3) == 0) off_all = ~off_all;
            off_one = N'($urandom());
            if ($urandom_range(0, 30) == 0) begin
                @(negedge clk_scan);
                #15;
                src_sel = ~src_sel;
            end
        end

        off_all = 1'b0;
        off_one = '0;
        @(negedge clk_scan);
        #15;
        src_sel = 1'b0;
        at_slot();
        chk(clk_out == '1, "R1 main source", clk_out, '1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule